// File: doc/BRIEF.md
# Multicast hash address filter

This block decides whether a received multicast frame is kept or dropped by hashing its destination address. The six destination address bytes arrive one per accepted cycle. A start strobe marks the first byte. A CRC-32 is accumulated over exactly those six bytes. Eight bits are then taken from the complemented, bit-reversed result, and that 8-bit value picks one bit out of a 256-bit table supplied by the surrounding logic. A set bit keeps the frame and a clear bit drops it. A pass-all control input overrides the table and keeps every multicast frame.

The table is presented as eight 32-bit words packed into one vector. Word k sits at bits [32k+31:32k]. The top three hash bits pick the word and the low five bits pick the bit inside it, so the hash value is also the flat bit index into the vector. A frame counts as multicast when bit 0 of its first address byte is 1. Frames that are not multicast produce no verdict at all. The verdict is a registered single-cycle pulse that appears in the cycle after the sixth byte is taken.

Top module: `mhf_filter`

## Requirements
- R1: The CRC register starts at all ones on each start byte, uses generator 0x04C11DB7, takes the bits of each byte least significant first, covers only the six address bytes, and is complemented at the end.
- R2: The hash is the top 8 bits of the bit-reversed complemented CRC. Equivalently, it equals bits [31:24] of the complemented register of the reflected form of the same CRC (generator 0xEDB88320, shifting right).
- R3: Table word k occupies hash_tbl[32k+31:32k]. Hash bits [7:5] select the word and bits [4:0] select the bit, so a hash h reads hash_tbl[h].
- R4: A hash of 8'hBF reads bit 31 of word 5, which is hash_tbl[191].
- R5: With pass_all_mc low, a multicast verdict has verdict_accept equal to the selected table bit.
- R6: With pass_all_mc high when the sixth byte is taken, every multicast verdict has verdict_accept = 1, whatever the table holds.
- R7: A frame is multicast when bit 0 of its first byte (the one carrying byte_sof) is 1. A frame with that bit at 0 never raises verdict_vld.
- R8: verdict_vld is high for exactly one cycle: the cycle after the one in which the sixth byte is taken. Idle cycles (byte_vld low) may fall between bytes.
- R9: A byte with byte_sof set always starts a new address, even in the middle of an earlier one. The earlier partial address gives no verdict.
- R10: After reset, and whenever verdict_vld is low, verdict_accept is 0. Bytes with byte_vld high but no byte_sof, arriving after an address is complete or before any start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | An address byte is present this cycle |
| byte_sof | input | 1 | The present byte is the first address byte |
| byte_dat | input | 8 | Address byte, first transmitted byte first |
| hash_tbl | input | 256 | Hash table, eight 32-bit words, word k at [32k+31:32k] |
| pass_all_mc | input | 1 | Keep every multicast frame |
| verdict_vld | output | 1 | Single-cycle verdict strobe for a multicast frame |
| verdict_accept | output | 1 | 1 = keep, 0 = drop; valid with verdict_vld |

## Verification
The assertions rely on byte_sof being asserted only together with byte_vld. They also rely on hash_tbl and pass_all_mc being stable during the cycle in which the sixth byte is taken. The bench drives strobes only from negative-edge tasks that raise byte_sof with byte_vld on the first byte. It changes the table and the control bit only while no address is in flight. Addresses are sent with zero to two idle cycles between bytes, restarted mid-address, and followed by stray bytes without a start strobe, so every counting path the assertions model is exercised.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam logic [31:0] CRC_GEN  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // One byte through a left-shifting CRC register, data bits fed LSB first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] cur,
                                                input logic [7:0]  din);
    logic [31:0] c;
    logic        fb;
    c = cur;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ din[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_GEN;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic [7:0]        in_dat,
  output logic              addr_done,
  output logic              addr_mc,
  output logic [HASH_W-1:0] crc_inv_low
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [31:0]      crc_q, crc_base, crc_nxt;
  logic             mc_q, mc_nxt, active, take;

  always_comb begin
    active   = (cnt_q != '0) && (cnt_q < LAST);
    take     = in_vld && (in_sof || active);
    crc_base = in_sof ? CRC_SEED : crc_q;
    crc_nxt  = crc_step_byte(crc_base, in_dat);
    cnt_nxt  = in_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
    mc_nxt   = in_sof ? in_dat[0] : mc_q;
  end

  assign addr_done   = take && (cnt_nxt == LAST);
  assign addr_mc     = mc_nxt;
  assign crc_inv_low = ~crc_nxt[HASH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
      mc_q  <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_nxt;
      crc_q <= crc_nxt;
      mc_q  <= mc_nxt;
    end
  end

endmodule

// File: rtl/mhf_hash_lookup.sv
module mhf_hash_lookup #(
  parameter int TABLE_BITS = 256,
  parameter int REG_W      = 32
) (
  input  logic [$clog2(TABLE_BITS)-1:0] crc_inv_low,
  input  logic [TABLE_BITS-1:0]         tbl,
  output logic                          hit
);
  localparam int HASH_W   = $clog2(TABLE_BITS);
  localparam int BIT_W    = $clog2(REG_W);
  localparam int SEL_W    = HASH_W - BIT_W;
  localparam int NUM_REGS = TABLE_BITS / REG_W;

  logic [HASH_W-1:0] hash;
  logic [REG_W-1:0]  words [NUM_REGS];
  logic [SEL_W-1:0]  sel;
  logic [BIT_W-1:0]  bsel;

  // Bit reversal: the lowest CRC bits become the top hash bits.
  for (genvar j = 0; j < HASH_W; j++) begin : g_rev
    assign hash[HASH_W-1-j] = crc_inv_low[j];
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    assign words[k] = tbl[k*REG_W +: REG_W];
  end

  assign sel  = hash[HASH_W-1 -: SEL_W];
  assign bsel = hash[BIT_W-1:0];
  assign hit  = words[sel][bsel];

endmodule

// File: rtl/mhf_verdict.sv
module mhf_verdict (
  input  logic clk,
  input  logic rst,
  input  logic addr_done,
  input  logic addr_mc,
  input  logic tbl_hit,
  input  logic pass_all,
  output logic out_vld,
  output logic out_acc
);
  logic fire;
  assign fire = addr_done && addr_mc;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_acc <= 1'b0;
    end else begin
      out_vld <= fire;
      out_acc <= fire && (pass_all || tbl_hit);
    end
  end

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int TABLE_BITS = 256,
  parameter int REG_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byte_vld,
  input  logic                  byte_sof,
  input  logic [7:0]            byte_dat,
  input  logic [TABLE_BITS-1:0] hash_tbl,
  input  logic                  pass_all_mc,
  output logic                  verdict_vld,
  output logic                  verdict_accept
);
  localparam int HASH_W = $clog2(TABLE_BITS);

  logic              done, mc, hit;
  logic [HASH_W-1:0] crc_low;

  mhf_crc_engine #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_crc (
    .clk(clk), .rst(rst),
    .in_vld(byte_vld), .in_sof(byte_sof), .in_dat(byte_dat),
    .addr_done(done), .addr_mc(mc), .crc_inv_low(crc_low)
  );

  mhf_hash_lookup #(.TABLE_BITS(TABLE_BITS), .REG_W(REG_W)) u_lkp (
    .crc_inv_low(crc_low), .tbl(hash_tbl), .hit(hit)
  );

  mhf_verdict u_vrd (
    .clk(clk), .rst(rst),
    .addr_done(done), .addr_mc(mc), .tbl_hit(hit), .pass_all(pass_all_mc),
    .out_vld(verdict_vld), .out_acc(verdict_accept)
  );

endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
  parameter int ADDR_BYTES = 6
) (
  input logic clk,
  input logic rst,
  input logic byte_vld,
  input logic byte_sof,
  input logic byte_lsb,
  input logic pass_all_mc,
  input logic verdict_vld,
  input logic verdict_accept
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] seen;
  logic             first_mc;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= '0;
      first_mc <= 1'b0;
    end else if (byte_vld && byte_sof) begin
      seen     <= CNT_W'(1);
      first_mc <= byte_lsb;
    end else if (byte_vld && seen != '0 && seen < LAST) begin
      seen <= seen + CNT_W'(1);
    end
  end

  // R8
  vld_after_last_byte_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_vld |-> (seen == LAST) && $past(byte_vld));

  // R8
  vld_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_vld |=> !verdict_vld);

  // R7
  vld_only_multicast_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_vld |-> first_mc);

  // R6
  pass_all_accepts_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_vld && $past(pass_all_mc)) |-> verdict_accept);

  // R10
  accept_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !verdict_vld |-> !verdict_accept);

endmodule

bind mhf_filter mhf_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sof(byte_sof),
  .byte_lsb(byte_dat[0]), .pass_all_mc(pass_all_mc),
  .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
);

// File: tb/sim_mhf_filter.sv
module sim_mhf_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [255:0] PAT = {8{32'h9E37_79B9}};
  localparam int NV = 8;
  // {pass_all, address}; first transmitted byte = address[47:40]
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 48'h01005E000001}, {1'b0, 48'h333300000001},
    {1'b0, 48'hFFFFFFFFFFFF}, {1'b0, 48'h0180C2000000},
    {1'b0, 48'h001122334455}, {1'b1, 48'h01005E7F1234},
    {1'b1, 48'h02AABBCCDDEE}, {1'b0, 48'hAB0000000000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic byte_vld = 1'b0, byte_sof = 1'b0, pass_all_mc = 1'b0;
  logic [7:0] byte_dat = '0;
  logic [255:0] hash_tbl = '0;
  logic verdict_vld, verdict_accept;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mhf_filter u0 (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sof(byte_sof),
    .byte_dat(byte_dat), .hash_tbl(hash_tbl), .pass_all_mc(pass_all_mc),
    .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  // Reflected CRC-32 reference (R1, R2)
  function automatic logic [7:0] ref_hash(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0] b;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 6; n++) begin
      b = a[47-8*n -: 8];
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ b[i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    c = ~c;
    return c[31:24];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // Caller is at a negedge. Sends six bytes, start on the first.
  task automatic send_frame(input logic [47:0] a, input int gap,
                            output logic early, output logic got_vld,
                            output logic got_acc, output logic late);
    early = 1'b0;
    for (int b = 0; b < 6; b++) begin
      if (b == 5) early = verdict_vld;
      byte_vld = 1'b1;
      byte_sof = (b == 0);
      byte_dat = a[47-8*b -: 8];
      @(negedge clk);
      if (b < 5 && gap > 0) begin
        byte_vld = 1'b0;
        byte_sof = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    got_vld = verdict_vld;
    got_acc = verdict_accept;
    byte_vld = 1'b0;
    byte_sof = 1'b0;
    @(negedge clk);
    late = verdict_vld;
  endtask

  task automatic run_check(input logic [47:0] a, input int gap,
                           input string req);
    logic e, v, ac, l, mc;
    mc = a[40];
    send_frame(a, gap, e, v, ac, l);
    chk({req, " R8 early"}, e, 1'b0);
    chk({req, " R7 vld"}, v, mc);
    chk({req, " R5 accept"}, ac, mc && (pass_all_mc || hash_tbl[ref_hash(a)]));
    chk({req, " R8 pulse"}, l, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [47:0] a;
    logic found, e, v, ac, l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset vld", verdict_vld, 1'b0);
    chk("R10 reset acc", verdict_accept, 1'b0);

    // Vector table: each address against the pattern and its inverse
    for (int i = 0; i < NV; i++) begin
      for (int ph = 0; ph < 2; ph++) begin
        hash_tbl = ph[0] ? ~PAT : PAT;
        pass_all_mc = VEC[i][48];
        run_check(VEC[i][47:0], i % 3, "R1,R2,R3 vec");
      end
    end
    pass_all_mc = 1'b0;

    // R4: find a multicast address hashing to 8'hBF
    found = 1'b0;
    a = '0;
    for (int k = 0; k < 8192 && !found; k++) begin
      a = {8'h01, 8'h00, 32'(k)};
      if (ref_hash(a) == 8'hBF) found = 1'b1;
    end
    chk("R4 search", found, 1'b1);
    hash_tbl = '0;
    hash_tbl[5*32+31] = 1'b1;
    send_frame(a, 0, e, v, ac, l);
    chk("R4 word5 bit31 set", ac, 1'b1);
    hash_tbl = '1;
    hash_tbl[191] = 1'b0;
    send_frame(a, 1, e, v, ac, l);
    chk("R4 word5 bit31 clear vld", v, 1'b1);
    chk("R4 word5 bit31 clear", ac, 1'b0);

    // R6: pass-all with empty table
    hash_tbl = '0;
    pass_all_mc = 1'b1;
    run_check(48'h01005E0000FB, 0, "R6 pass");
    run_check(48'h00AA55AA55AA, 0, "R6 unicast");
    pass_all_mc = 1'b0;
    run_check(48'h01005E0000FB, 0, "R5 empty");

    // R9: partial address restarted by a new start byte
    hash_tbl = PAT;
    for (int b = 0; b < 3; b++) begin
      byte_vld = 1'b1; byte_sof = (b == 0); byte_dat = 8'h01 + 8'(b);
      @(negedge clk);
    end
    chk("R9 partial no vld", verdict_vld, 1'b0);
    run_check(48'h333300000002, 0, "R9 restart");
    // R9: start strobe in mid-address without idle
    for (int b = 0; b < 4; b++) begin
      byte_vld = 1'b1; byte_sof = (b == 0); byte_dat = 8'hF1;
      @(negedge clk);
    end
    hash_tbl = ~PAT;
    run_check(48'h01005E112233, 0, "R9 mid restart");

    // R10: stray bytes without start are ignored
    found = 1'b0;
    for (int b = 0; b < 8; b++) begin
      byte_vld = 1'b1; byte_sof = 1'b0; byte_dat = 8'h01;
      @(negedge clk);
      if (verdict_vld) found = 1'b1;
    end
    byte_vld = 1'b0;
    @(negedge clk);
    if (verdict_vld) found = 1'b1;
    chk("R10 stray bytes", found, 1'b0);
    run_check(48'hFFFFFFFFFFFF, 2, "R10 after stray");

    finish_run();
  end

endmodule